// File: doc/BRIEF.md
# Error-Correcting Register File

This block is a register file with two read ports and one write port. Every entry is protected by a single-error-correct, double-error-detect code. Each write encodes the incoming word into a 39-bit codeword: 32 data bits, six Hamming check bits and one overall parity bit. Each read decodes the codeword it fetches. When a read finds a single flipped bit, it repairs the bit on the fly, returns the correct word and reports a recoverable event. When a read finds two flipped bits, it cannot repair the word. It reports an uncorrectable event and raises an error-exception request toward the pipeline.

A status input tells the block that the processor is already running its exception handler. An uncorrectable read in that state also sets a separate escalation bit, which marks a likely fatal condition.

A test port XORs a chosen mask into one stored codeword, so that single or double faults can be planted on purpose. Reads have a latency of one cycle. A write and a read of the same address in the same cycle return the new data.

Top module: `regfile_secded`

## Requirements
- R1: A word written to an entry is returned unchanged by a later read of that entry on either port, with `ecc_event` equal to 0 and `exc_req` low.
- R2: If exactly one of the 39 stored codeword bits is flipped, a read returns the originally written word, sets `ecc_event[1]` and keeps `exc_req` low. This includes the overall parity bit, which is codeword bit 0.
- R3: If exactly two stored codeword bits are flipped, a read sets `ecc_event[2]` and raises `exc_req`. The returned data is unspecified.
- R4: `ecc_event[0]` is set only when `exc_req` is raised while `in_handler` is high. A single-bit error with `in_handler` high leaves it clear.
- R5: The two read ports decode independently. `exc_req` and each bit of `ecc_event` are the OR of the two ports' results in the same cycle.
- R6: If a read and a write to the same address happen in the same cycle, the read returns the newly written word with no event.
- R7: A write always stores freshly encoded check bits, which clears any earlier injected fault. If a write and an injection target the same entry in the same cycle, the write wins.
- R8: Read data and events appear in the cycle after a read is issued with its enable high. `ecc_event` and `exc_req` are 0 in any cycle that follows one with no read enabled.
- R9: After reset, every entry reads as 0 with no event, and `exc_req` and `ecc_event` are 0.
- R10: When `inj_en` is high at a clock edge, stored codeword bit i of entry `inj_addr` is inverted for every set bit i of `inj_mask`. Injecting the same mask twice restores the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write enable |
| waddr | input | 5 | Write address |
| wdata | input | 32 | Write data |
| ra_en | input | 1 | Read enable, port A |
| ra_addr | input | 5 | Read address, port A |
| rb_en | input | 1 | Read enable, port B |
| rb_addr | input | 5 | Read address, port B |
| in_handler | input | 1 | Processor is in exception-handler mode |
| inj_en | input | 1 | Fault-injection strobe |
| inj_addr | input | 5 | Entry receiving the injected fault |
| inj_mask | input | 39 | Codeword bits to invert |
| ra_data | output | 32 | Corrected read data, port A |
| rb_data | output | 32 | Corrected read data, port B |
| exc_req | output | 1 | Error-exception request |
| ecc_event | output | 3 | Bit 0 escalated, bit 1 recoverable, bit 2 uncorrectable |

## Verification
Two things can happen in the same cycle: a recoverable correction on one read port and an uncorrectable detection on the other. To make both happen together, one entry is planted with a single-bit fault and a second with a two-bit fault, and then both are read at once, in both port orders and with `in_handler` at each level. The event bus must show the merged bits, including escalation only when the handler flag is high. The port that holds the single fault must still return its corrected word.

// File: rtl/regfile_secded.sv
module regfile_secded #(
  parameter int DEPTH = 32,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     ra_en,
  input  logic [$clog2(DEPTH)-1:0] ra_addr,
  input  logic                     rb_en,
  input  logic [$clog2(DEPTH)-1:0] rb_addr,
  input  logic                     in_handler,
  input  logic                     inj_en,
  input  logic [$clog2(DEPTH)-1:0] inj_addr,
  input  logic [DW+6:0]            inj_mask,
  output logic [DW-1:0]            ra_data,
  output logic [DW-1:0]            rb_data,
  output logic                     exc_req,
  output logic [2:0]               ecc_event
);
  localparam int CB = 6;
  localparam int HN = DW + CB;
  localparam int CW = HN + 1;

  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= HN; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k = k + 1;
      end
    for (int j = 0; j < CB; j++)
      for (int p = 1; p <= HN; p++)
        if (p[j] && (p != (1 << j))) c[1 << j] = c[1 << j] ^ c[p];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [DW+1:0] dec(input logic [CW-1:0] cw);
    logic [CW-1:0] f;
    logic [CB-1:0] s;
    logic [DW-1:0] d;
    logic ce, ue;
    int k;
    s = '0;
    for (int p = 1; p <= HN; p++)
      if (cw[p]) s = s ^ p[CB-1:0];
    f = cw;
    ce = 1'b0;
    ue = 1'b0;
    if (^cw) begin
      if (s == '0) ce = 1'b1;
      else if (int'(s) <= HN) begin
        f[s] = ~f[s];
        ce = 1'b1;
      end else ue = 1'b1;
    end else if (s != '0) ue = 1'b1;
    d = '0;
    k = 0;
    for (int p = 1; p <= HN; p++)
      if ((p & (p - 1)) != 0) begin
        d[k] = f[p];
        k = k + 1;
      end
    return {ue, ce, d};
  endfunction

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] cw_a, cw_b;
  logic          va, vb;
  logic [DW+1:0] da, db;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (we)     mem[waddr]    <= enc(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_a <= '0;
      cw_b <= '0;
      va   <= 1'b0;
      vb   <= 1'b0;
    end else begin
      va <= ra_en;
      vb <= rb_en;
      if (ra_en) cw_a <= (we && waddr == ra_addr) ? enc(wdata) : mem[ra_addr];
      if (rb_en) cw_b <= (we && waddr == rb_addr) ? enc(wdata) : mem[rb_addr];
    end
  end

  assign da      = dec(cw_a);
  assign db      = dec(cw_b);
  assign ra_data = da[DW-1:0];
  assign rb_data = db[DW-1:0];

  logic ce_any, ue_any;
  assign ce_any    = (va & da[DW]) | (vb & db[DW]);
  assign ue_any    = (va & da[DW+1]) | (vb & db[DW+1]);
  assign exc_req   = ue_any;
  assign ecc_event = {ue_any, ce_any, ue_any & in_handler};
endmodule

// File: rtl/regfile_secded_chk.sv
module regfile_secded_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic [DW-1:0] wdata,
  input logic          ra_en,
  input logic [AW-1:0] ra_addr,
  input logic          rb_en,
  input logic [AW-1:0] rb_addr,
  input logic          in_handler,
  input logic [DW-1:0] ra_data,
  input logic [DW-1:0] rb_data,
  input logic          exc_req,
  input logic [2:0]    ecc_event
);
  assert_exc_has_ue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ecc_event[2]);

  assert_escalate_only_in_handler_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_event[0] |-> (exc_req && in_handler));

  assert_idle_no_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ra_en) && !$past(rb_en)) |-> (ecc_event == 3'b000 && !exc_req));

  assert_bypass_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && ra_en && waddr == ra_addr) |-> (ra_data == $past(wdata) && ecc_event == 3'b000));

  assert_bypass_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && rb_en && waddr == rb_addr) |-> (rb_data == $past(wdata)));
endmodule

bind regfile_secded regfile_secded_chk #(.AW($clog2(DEPTH)), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
  .ra_en(ra_en), .ra_addr(ra_addr), .rb_en(rb_en), .rb_addr(rb_addr),
  .in_handler(in_handler), .ra_data(ra_data), .rb_data(rb_data),
  .exc_req(exc_req), .ecc_event(ecc_event)
);

// File: tb/regfile_secded_tb_top.sv
`timescale 1ns/1ps
module regfile_secded_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0, ra_en = 0, rb_en = 0, in_handler = 0, inj_en = 0;
  logic [4:0]  waddr = 0, ra_addr = 0, rb_addr = 0, inj_addr = 0;
  logic [31:0] wdata = 0;
  logic [38:0] inj_mask = 0;
  logic [31:0] ra_data, rb_data;
  logic        exc_req;
  logic [2:0]  ecc_event;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  regfile_secded dut_i (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .ra_en(ra_en), .ra_addr(ra_addr), .rb_en(rb_en), .rb_addr(rb_addr),
    .in_handler(in_handler), .inj_en(inj_en), .inj_addr(inj_addr),
    .inj_mask(inj_mask), .ra_data(ra_data), .rb_data(rb_data),
    .exc_req(exc_req), .ecc_event(ecc_event)
  );

  typedef struct packed {
    logic [4:0]  a;
    logic [31:0] d;
    logic [38:0] m;
    logic        h;
    logic [2:0]  ev;
    logic        dchk;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{5'd3,  32'hA5A5_0F0F, 39'h0,                 1'b0, 3'b000, 1'b1},
    '{5'd7,  32'hDEAD_BEEF, 39'h1,                 1'b0, 3'b010, 1'b1},
    '{5'd8,  32'h1234_5678, 39'h1 << 38,           1'b0, 3'b010, 1'b1},
    '{5'd9,  32'hFFFF_FFFF, 39'h1 << 16,           1'b1, 3'b010, 1'b1},
    '{5'd10, 32'hCAFE_F00D, (39'h1 << 5) | (39'h1 << 20), 1'b0, 3'b100, 1'b0},
    '{5'd11, 32'h0000_0000, 39'h3,                 1'b1, 3'b101, 1'b0},
    '{5'd31, 32'h8000_0001, 39'h1 << 3,            1'b0, 3'b010, 1'b1},
    '{5'd0,  32'h7654_3210, 39'h3 << 37,           1'b0, 3'b100, 1'b0}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); we = 1; waddr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic inj(logic [4:0] a, logic [38:0] m);
    @(negedge clk); inj_en = 1; inj_addr = a; inj_mask = m;
    @(negedge clk); inj_en = 0;
  endtask

  task automatic rd(logic [4:0] a, logic [4:0] b);
    @(negedge clk); ra_en = 1; ra_addr = a; rb_en = 1; rb_addr = b;
    @(negedge clk); ra_en = 0; rb_en = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    #45 rst_n = 1;
    @(negedge clk);
    check("R9 exc after reset", exc_req, 0);
    check("R9 events after reset", ecc_event, 0);
    rd(5, 6);
    check("R9 entry zero A", ra_data, 0);
    check("R9 entry zero B", rb_data, 0);
    check("R9 no event on zero entry", ecc_event, 0);

    foreach (VEC[i]) begin
      wr(VEC[i].a, VEC[i].d);
      if (VEC[i].m != 0) inj(VEC[i].a, VEC[i].m);
      in_handler = VEC[i].h;
      rd(VEC[i].a, VEC[i].a);
      check("R1/R2/R3/R4 events", ecc_event, VEC[i].ev);
      check("R3 exc_req", exc_req, VEC[i].ev[2]);
      if (VEC[i].dchk) begin
        check("R1/R2 data A", ra_data, VEC[i].d);
        check("R1/R2 data B", rb_data, VEC[i].d);
      end
      in_handler = 0;
    end

    // R8: event only in cycle after an enabled read
    wr(12, 32'h0BAD_F00D);
    inj(12, 39'h6);
    rd(12, 12);
    check("R3 double on entry 12", ecc_event, 3'b100);
    @(negedge clk);
    check("R8 idle cycle clears events", ecc_event, 0);
    check("R8 idle cycle clears exc", exc_req, 0);

    // R7: rewrite repairs
    wr(12, 32'h1111_2222);
    rd(12, 12);
    check("R7 rewrite clean events", ecc_event, 0);
    check("R7 rewrite data", ra_data, 32'h1111_2222);

    // R7: write beats same-cycle injection
    @(negedge clk); we = 1; waddr = 13; wdata = 32'h3333_4444;
    inj_en = 1; inj_addr = 13; inj_mask = 39'h18;
    @(negedge clk); we = 0; inj_en = 0;
    rd(13, 13);
    check("R7 write wins events", ecc_event, 0);
    check("R7 write wins data", rb_data, 32'h3333_4444);

    // R6: same-cycle write/read bypass
    wr(14, 32'h5555_5555);
    @(negedge clk); we = 1; waddr = 14; wdata = 32'h9999_AAAA;
    ra_en = 1; ra_addr = 14; rb_en = 1; rb_addr = 14;
    @(negedge clk); we = 0; ra_en = 0; rb_en = 0;
    check("R6 bypass A", ra_data, 32'h9999_AAAA);
    check("R6 bypass B", rb_data, 32'h9999_AAAA);
    check("R6 bypass events", ecc_event, 0);

    // R5: both ports, merged events
    wr(20, 32'hABCD_0123);
    wr(21, 32'h4567_89EF);
    inj(20, 39'h1 << 9);
    inj(21, (39'h1 << 2) | (39'h1 << 30));
    in_handler = 1;
    rd(20, 21);
    check("R5 merged events handler", ecc_event, 3'b111);
    check("R5 exc merged", exc_req, 1);
    check("R5 corrected A", ra_data, 32'hABCD_0123);
    in_handler = 0;
    rd(21, 20);
    check("R5 merged events no handler", ecc_event, 3'b110);
    check("R5 corrected B", rb_data, 32'hABCD_0123);

    // R10: same mask twice restores entry
    wr(22, 32'hFEED_FACE);
    inj(22, 39'h1 << 25);
    inj(22, 39'h1 << 25);
    rd(22, 22);
    check("R10 double inject restores events", ecc_event, 0);
    check("R10 double inject restores data", ra_data, 32'hFEED_FACE);

    done = 1;
    summary();
  end
endmodule